// File: doc/BRIEF.md
# Decaying Tone Sample Generator

This block turns a fast system clock into a stream of 16-bit signed audio samples that carry a sinusoid whose loudness dies away over time. A fractional divider inside the block derives the audio-rate sample strobe from the system clock, so the average sample rate is exact even when the clock is not a whole multiple of it. On each accepted strobe the block reads one entry from a sine table and one entry from an envelope table. It then advances both table pointers, each by its own programmable step. The tone step sets the pitch, and the decay step sets how fast the tone fades.

The envelope table holds a curve that rises towards full scale and saturates there. The gain applied to the sine value is the complement of that curve, so the output grows quieter as the envelope pointer moves forward. The envelope pointer stops at the last table entry, whose gain is zero, so a fully decayed tone stays silent until a trigger pulse restarts it. The scaling uses no multiplier. A shift-and-add unit consumes one gain bit per clock, and the finished sample leaves the block with a one-cycle valid pulse. Both tables are computed at elaboration time.

Top module: `decay_tone_gen`

## Requirements
- R1: In any window of CLK_HZ consecutive clocks, the internal strobe fires exactly SAMPLE_HZ times. Each accepted strobe yields exactly one `sample_valid` pulse, and that pulse lasts one clock.
- R2: Sine entry i (0..1023) equals round(32767·sin(2πi/1024)). It is selected by bits [31:22] of a 32-bit phase register. The phase register starts at 0, grows by `tone_step` on every accepted strobe and wraps modulo 2^32.
- R3: Envelope entry k equals round(32767·(1−e^(−8k/1024))) for k below 1023, and entry 1023 equals 32767. The gain applied is 32767 minus the entry.
- R4: The envelope pointer is a 32-bit register whose bits [31:22] select the entry. It grows by `decay_step` on every accepted strobe. If the addition would carry out, the pointer saturates at all ones and then stays there, so every later sample is 0.
- R5: Each output sample equals floor(sine·gain / 2^15), computed without a multiplier by a shift-and-add unit that takes one gain bit per clock.
- R6: A sample uses the pointer values from before its own strobe advances them. The first sample after reset therefore uses entry 0 of both tables.
- R7: A high `trigger` sets the envelope pointer to 0 on the next clock, even when a strobe advances it in the same cycle. The phase register is not affected.
- R8: A strobe that arrives while the scaling unit is busy is ignored: neither pointer moves and no sample is produced. Such a strobe sets `overrun`, which stays high until reset.
- R9: During and right after reset, `sample` is 0, `sample_valid` is 0 and `overrun` is 0.
- R10: `sample` changes only in a cycle in which `sample_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_step | input | 32 | Amount added to the sine phase per sample (pitch) |
| decay_step | input | 32 | Amount added to the envelope pointer per sample (decay rate) |
| trigger | input | 1 | Restarts the envelope at full loudness |
| sample | output | 16 | Scaled signed output sample |
| sample_valid | output | 1 | One-clock pulse marking a new sample |
| overrun | output | 1 | Sticky flag: a strobe arrived while scaling was busy |

## Verification
With both steps at zero, every sample must be zero, and the bench counts valid pulses over one divider period. This isolates the fractional strobe rate from the table contents. Three tone steps are then run with no decay: one table entry per sample, an odd step that hits scattered entries, and a large step that wraps the phase. These separate phase-indexing and wrap errors from errors in the shift-and-add result at full gain. A fast decay step drives the envelope through its whole table into saturation, which exposes errors in the complement, the rounding and the final silence. A trigger run and a second instance whose strobes come faster than the scaling finishes then show whether the envelope restarts correctly and whether dropped strobes leave the pointer sequence intact.

// File: rtl/decay_tone_gen.sv
module decay_tone_gen #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SAMPLE_HZ = 48_000,
  parameter int DW        = 16,
  parameter int PW        = 32,
  parameter int SINE_BITS = 10,
  parameter int ENV_BITS  = 10,
  parameter int ENV_SPAN  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        tone_step,
  input  logic [PW-1:0]        decay_step,
  input  logic                 trigger,
  output logic signed [DW-1:0] sample,
  output logic                 sample_valid,
  output logic                 overrun
);
  localparam int  GW     = DW - 1;
  localparam int  FULL   = (1 << (DW - 1)) - 1;
  localparam int  SINE_N = 1 << SINE_BITS;
  localparam int  ENV_N  = 1 << ENV_BITS;
  localparam int  DIV_W  = $clog2(CLK_HZ) + 1;
  localparam int  CW     = $clog2(GW);
  localparam int  AW     = 2 * DW;
  localparam real PI     = 3.14159265358979;

  logic signed [DW-1:0] sine_rom [SINE_N];
  logic        [DW-1:0] env_rom  [ENV_N];

  function automatic int q_round(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction

  initial begin
    for (int i = 0; i < SINE_N; i++)
      sine_rom[i] = DW'(q_round(real'(FULL) * $sin(2.0 * PI * real'(i) / real'(SINE_N))));
    for (int k = 0; k < ENV_N; k++)
      env_rom[k] = (k == ENV_N - 1) ? DW'(FULL) :
        DW'(q_round(real'(FULL) * (1.0 - $exp(-real'(ENV_SPAN) * real'(k) / real'(ENV_N)))));
  end

  logic [DIV_W-1:0]    div_acc;
  logic [PW-1:0]       phase, env_ph;
  logic                busy;
  logic [CW-1:0]       cnt;
  logic signed [AW-1:0] mcand, acc;
  logic [GW-1:0]       gmask;

  wire [DIV_W-1:0] div_sum = div_acc + DIV_W'(SAMPLE_HZ);
  wire             fire    = div_sum >= DIV_W'(CLK_HZ);
  wire [PW:0]      env_sum = {1'b0, env_ph} + {1'b0, decay_step};
  wire [PW-1:0]    env_nx  = env_sum[PW] ? '1 : env_sum[PW-1:0];
  wire [DW-1:0]    env_val = env_rom[env_ph[PW-1 -: ENV_BITS]];
  wire [DW-1:0]    gain    = DW'(FULL) - env_val;
  wire signed [AW-1:0] acc_nx = acc + (gmask[0] ? mcand : AW'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_acc      <= '0;
      phase        <= '0;
      env_ph       <= '0;
      busy         <= 1'b0;
      cnt          <= '0;
      mcand        <= '0;
      acc          <= '0;
      gmask        <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      div_acc <= fire ? div_sum - DIV_W'(CLK_HZ) : div_sum;
      if (fire && !busy) begin
        mcand  <= AW'(sine_rom[phase[PW-1 -: SINE_BITS]]);
        gmask  <= gain[GW-1:0];
        acc    <= '0;
        cnt    <= '0;
        busy   <= 1'b1;
        phase  <= phase + tone_step;
        env_ph <= env_nx;
      end else if (fire) begin
        overrun <= 1'b1;
      end
      if (busy) begin
        acc   <= acc_nx;
        mcand <= mcand <<< 1;
        gmask <= gmask >> 1;
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(GW - 1)) begin
          busy         <= 1'b0;
          sample       <= acc_nx[DW+GW-1:GW];
          sample_valid <= 1'b1;
        end
      end
      if (trigger) env_ph <= '0;
    end
  end
endmodule

module decay_tone_gen_chk #(
  parameter int DW = 16,
  parameter int PW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trigger,
  input logic signed [DW-1:0] sample,
  input logic                 sample_valid,
  input logic                 overrun,
  input logic [PW-1:0]        env_ph
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |=> !sample_valid); // R1
  AST_ENV_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (&env_ph && !trigger) |=> &env_ph); // R4
  AST_TRIGGER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) trigger |=> env_ph == '0); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sample_valid |-> $stable(sample)); // R10
endmodule

bind decay_tone_gen decay_tone_gen_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trigger(trigger), .sample(sample),
  .sample_valid(sample_valid), .overrun(overrun), .env_ph(env_ph)
);

// File: tb/decay_tone_gen_test.sv
module decay_tone_gen_test;
  localparam real PI = 3.14159265358979;
  localparam logic [31:0] FAST_TONE  = 32'h0123_4567;
  localparam logic [31:0] FAST_DECAY = 32'h0100_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_fast_n = 1'b0;
  logic [31:0] tone_step = '0;
  logic [31:0] decay_step = '0;
  logic trigger = 1'b0;
  logic signed [15:0] smp, fsmp;
  logic sv, fsv, ovr, fovr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] m_ph [2];
  logic [31:0] m_env [2];
  int last_val;

  always #4 clk = ~clk;

  decay_tone_gen #(.CLK_HZ(1000), .SAMPLE_HZ(27)) uut (
    .clk(clk), .rst_n(rst_n), .tone_step(tone_step), .decay_step(decay_step),
    .trigger(trigger), .sample(smp), .sample_valid(sv), .overrun(ovr));

  decay_tone_gen #(.CLK_HZ(100), .SAMPLE_HZ(10)) uut_fast (
    .clk(clk), .rst_n(rst_fast_n), .tone_step(FAST_TONE), .decay_step(FAST_DECAY),
    .trigger(1'b0), .sample(fsmp), .sample_valid(fsv), .overrun(fovr));

  function automatic int q_round(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction
  function automatic int ref_sine(input int i);
    return q_round(32767.0 * $sin(2.0 * PI * real'(i) / 1024.0));
  endfunction
  function automatic int ref_gain(input int k);
    if (k == 1023) return 0;
    return 32767 - q_round(32767.0 * (1.0 - $exp(-8.0 * real'(k) / 1024.0)));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic take_sample(input int which, input string req);
    int waited = 0;
    longint p;
    int expv, got;
    logic [32:0] es;
    logic [31:0] ts, ds;
    @(negedge clk);
    while (!(which == 1 ? fsv : sv) && waited < 600) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 600) begin
      check(1'b0, {req, " no valid"}, 0, 1);
      return;
    end
    p = longint'(ref_sine(int'(m_ph[which][31:22]))) * longint'(ref_gain(int'(m_env[which][31:22])));
    expv = int'(p >>> 15);
    got = (which == 1) ? int'(fsmp) : int'(smp);
    last_val = got;
    check(got == expv, req, got, expv);
    ts = (which == 1) ? FAST_TONE : tone_step;
    ds = (which == 1) ? FAST_DECAY : decay_step;
    m_ph[which] = m_ph[which] + ts;
    es = {1'b0, m_env[which]} + {1'b0, ds};
    m_env[which] = es[32] ? 32'hFFFF_FFFF : es[31:0];
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(smp == 0, "R9 sample in reset", int'(smp), 0);
    check(sv == 1'b0, "R9 valid in reset", int'(sv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp == 0 && sv == 1'b0, "R9 sample/valid after reset", int'(smp), 0);
    check(ovr == 1'b0, "R9 overrun after reset", int'(ovr), 0);
  endtask

  task automatic test_rate();
    int n = 0;
    take_sample(0, "R6 first sample uses entry 0");
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      if (sv) begin
        n++;
        check(smp == 0, "R1 zero-step sample", int'(smp), 0);
      end
    end
    check(n == 27, "R1 pulses per divider period", n, 27);
    check(ovr == 1'b0, "R8 no overrun at slow rate", int'(ovr), 0);
  endtask

  task automatic test_tone();
    decay_step = '0;
    tone_step = 32'h0040_0000;
    for (int i = 0; i < 20; i++) take_sample(0, "R2 R5 one entry per sample");
    tone_step = 32'h0555_5555;
    for (int i = 0; i < 20; i++) take_sample(0, "R2 R5 odd step");
    tone_step = 32'hF000_0000;
    for (int i = 0; i < 12; i++) take_sample(0, "R2 wrap step");
  endtask

  task automatic test_decay();
    tone_step = 32'h0123_4567;
    decay_step = 32'h0400_0000;
    for (int i = 0; i < 64; i++) take_sample(0, "R3 R5 decaying sample");
    for (int i = 0; i < 8; i++) begin
      take_sample(0, "R4 saturated sample");
      check(last_val == 0, "R4 silent once decayed", last_val, 0);
    end
  endtask

  task automatic test_trigger();
    logic [31:0] ph_before;
    ph_before = m_ph[0];
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    m_env[0] = '0;
    check(m_ph[0] == ph_before, "R7 phase model untouched", 0, 0);
    for (int i = 0; i < 10; i++) take_sample(0, "R7 restarted envelope");
    decay_step = '0;
  endtask

  task automatic test_overrun();
    int n = 0;
    rst_fast_n = 1'b1;
    @(negedge clk);
    check(fovr == 1'b0, "R9 fast overrun after reset", int'(fovr), 0);
    for (int i = 0; i < 12; i++) take_sample(1, "R8 dropped strobes keep sequence");
    check(fovr == 1'b1, "R8 overrun set", int'(fovr), 1);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (fsv) n++;
    end
    check(n == 10, "R8 one sample per two strobes", n, 10);
    check(fovr == 1'b1, "R8 overrun sticky", int'(fovr), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_ph[0] = '0; m_ph[1] = '0; m_env[0] = '0; m_env[1] = '0;
    test_reset();
    test_rate();
    test_tone();
    test_decay();
    test_trigger();
    test_overrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule